// File: doc/BRIEF.md
# Repeat-Mode DMA Channel

This block is a single DMA channel that copies data, one unit per request, from a source address to a destination address over a simple synchronous memory bus. Software loads a start source address, a start destination address and a unit count through a small register port, then enables the channel. After that, every request moves exactly one byte or one 16-bit word. A request comes from a software strobe or from the rising edge of a hardware request pin, such as a timer underflow.

Each transfer is a read cycle followed by a write cycle and a bookkeeping cycle. The configuration chooses which address advances after each unit: the source, the destination, or neither. In repeat mode the channel reloads its start addresses and count when the count runs out, and it keeps running with no software help. This is how a table in memory can be streamed out to an output port at a fixed request rate, for example to drive several PWM-like pins. In single mode the channel stops, pulses `done` and clears its enable bit.

Top module: `dma_repeat_chan`

## Requirements
- R1: After reset the channel is idle: `busy`, `done`, `mem_rd` and `mem_wr` are 0, and the control and count registers read 0.
- R2: With word units (control bit 1 = 1), one request reads two bytes at the current source address and writes them to the current destination address, low byte at the lower address.
- R3: With byte units (control bit 1 = 0), one request copies only the byte at the source to the destination, and the neighbouring destination byte is left unchanged.
- R4: Control bits 3:2 select the address step after each unit: 1 advances the source, 2 advances the destination, 0 (and 3) advance neither. The step is 1 for byte units and 2 for word units.
- R5: A rising edge on `hw_req` is one request. Holding the pin high does not raise any further requests.
- R6: A request that arrives while a transfer is running is kept pending and served next. Any further requests before that one is served merge into it.
- R7: Reading register 3 returns the number of units that remain. Register 1 and register 2 return the current source and destination addresses.
- R8: In single mode (control bit 4 = 0), the transfer that brings the count to zero pulses `done` high for exactly one cycle and clears the enable bit (control bit 0). Later requests then move nothing.
- R9: In repeat mode (control bit 4 = 1), the transfer that exhausts the count reloads the start addresses and the count, keeps the channel enabled and raises no `done`.
- R10: While the enable bit is 0, requests move no data and leave the count unchanged. Writing 1 to control bit 5 is the software request strobe.
- R11: Every bus write comes in the cycle right after a bus read, and `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 control, 1 source, 2 destination, 3 count |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data (combinational) |
| hw_req | input | 1 | Hardware request, active on its rising edge |
| mem_rd | output | 1 | Bus read strobe |
| mem_wr | output | 1 | Bus write strobe |
| mem_word | output | 1 | 1 for a word access, 0 for a byte access |
| mem_addr | output | 16 | Bus byte address |
| mem_wdata | output | 16 | Bus write data |
| mem_rdata | input | 16 | Bus read data, valid the cycle after `mem_rd` |
| busy | output | 1 | High while a transfer is in progress |
| done | output | 1 | One-cycle pulse when single mode completes |

## Verification
A corrupted current address shows up on `mem_addr` during the next read or write cycle, and it can also be read back through register 1 or 2 about five cycles after the request. A wrong count or reload shows up in register 3 right after the update cycle. It also shows up as a `done` pulse that comes too early, too late or not at all. A lost or duplicated pending request shows up as a count that is off by one once the channel is idle again. A broken read-then-write order shows up as a destination byte that holds stale or neighbouring data.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_WRITE  = 2'd2,
        ST_UPDATE = 2'd3
    } dmach_st_e;

    // register select codes
    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_SRC  = 2'd1;
    localparam logic [1:0] REG_DST  = 2'd2;
    localparam logic [1:0] REG_CNT  = 2'd3;

    // control bit positions
    localparam int CTL_EN   = 0;
    localparam int CTL_WORD = 1;
    localparam int CTL_INC  = 2;   // two bits: 3:2
    localparam int CTL_RPT  = 4;
    localparam int CTL_GO   = 5;

    // address step selector values
    localparam logic [1:0] STEP_SRC = 2'd1;
    localparam logic [1:0] STEP_DST = 2'd2;

endpackage

// File: rtl/dmach_req.sv
module dmach_req (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sw_go,
    input  logic hw_req,
    input  logic take,
    output logic pend
);
    typedef struct packed {
        logic hw_prev;
        logic pend;
    } req_t;

    req_t req_d, req_q;
    logic hw_rise;

    assign hw_rise = hw_req && !req_q.hw_prev;

    always_comb begin
        req_d         = req_q;
        req_d.hw_prev = hw_req;
        if (take) begin
            req_d.pend = 1'b0;
        end
        if (!en) begin
            req_d.pend = 1'b0;
        end else if (sw_go || hw_rise) begin
            req_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q <= req_d;
        end
    end

    assign pend = req_q.pend;

    // R10
    pend_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !req_q.pend);

    // R5
    level_no_retrig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q.hw_prev && hw_req && !sw_go && !req_q.pend) |=> !req_q.pend);

endmodule

// File: rtl/dmach_step.sv
module dmach_step #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic          inc_on,
    input  logic          word,
    output logic [AW-1:0] next
);
    localparam int WSTEP = DW / 8;

    logic [AW-1:0] delta;

    always_comb begin
        delta = word ? AW'(WSTEP) : AW'(1);
        next  = inc_on ? (addr + delta) : addr;
    end
endmodule

// File: rtl/dma_repeat_chan.sv
module dma_repeat_chan #(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int RW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_addr,
    input  logic [RW-1:0] cfg_wdata,
    output logic [RW-1:0] cfg_rdata,
    input  logic          hw_req,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          mem_word,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done
);
    import dmach_pkg::*;

    localparam int NPTR = 2;  // index 0 source, 1 destination

    typedef struct packed {
        dmach_st_e     st;
        logic          en;
        logic          word;
        logic          rpt;
        logic [1:0]    inc;
        logic [AW-1:0] bsrc;
        logic [AW-1:0] bdst;
        logic [AW-1:0] csrc;
        logic [AW-1:0] cdst;
        logic [CW-1:0] bcnt;
        logic [CW-1:0] ccnt;
        logic          done;
    } chan_t;

    chan_t ch_d, ch_q;

    logic          ctrl_wr;
    logic          en_now;
    logic          sw_go;
    logic          pend;
    logic          take;
    logic [AW-1:0] ptr_cur  [NPTR];
    logic [AW-1:0] ptr_next [NPTR];
    logic [NPTR-1:0] ptr_inc;

    assign ctrl_wr = cfg_we && (cfg_addr == REG_CTRL);
    assign en_now  = ctrl_wr ? cfg_wdata[CTL_EN] : ch_q.en;
    assign sw_go   = ctrl_wr && cfg_wdata[CTL_GO];

    dmach_req u_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en_now),
        .sw_go  (sw_go),
        .hw_req (hw_req),
        .take   (take),
        .pend   (pend)
    );

    assign ptr_cur[0] = ch_q.csrc;
    assign ptr_cur[1] = ch_q.cdst;

    for (genvar gi = 0; gi < NPTR; gi++) begin : g_step
        assign ptr_inc[gi] = (ch_q.inc == ((gi == 0) ? STEP_SRC : STEP_DST));
        dmach_step #(.AW(AW), .DW(DW)) u_step (
            .addr   (ptr_cur[gi]),
            .inc_on (ptr_inc[gi]),
            .word   (ch_q.word),
            .next   (ptr_next[gi])
        );
    end

    always_comb begin
        ch_d      = ch_q;
        ch_d.done = 1'b0;
        take      = 1'b0;

        if (cfg_we) begin
            case (cfg_addr)
                REG_CTRL: begin
                    ch_d.en   = cfg_wdata[CTL_EN];
                    ch_d.word = cfg_wdata[CTL_WORD];
                    ch_d.inc  = cfg_wdata[CTL_INC +: 2];
                    ch_d.rpt  = cfg_wdata[CTL_RPT];
                end
                REG_SRC: begin
                    ch_d.bsrc = cfg_wdata[AW-1:0];
                    ch_d.csrc = cfg_wdata[AW-1:0];
                end
                REG_DST: begin
                    ch_d.bdst = cfg_wdata[AW-1:0];
                    ch_d.cdst = cfg_wdata[AW-1:0];
                end
                default: begin
                    ch_d.bcnt = cfg_wdata[CW-1:0];
                    ch_d.ccnt = cfg_wdata[CW-1:0];
                end
            endcase
        end

        case (ch_q.st)
            ST_IDLE: begin
                if (ch_q.en && pend && (ch_q.ccnt != '0)) begin
                    take    = 1'b1;
                    ch_d.st = ST_READ;
                end
            end
            ST_READ:  ch_d.st = ST_WRITE;
            ST_WRITE: ch_d.st = ST_UPDATE;
            default: begin
                ch_d.st   = ST_IDLE;
                ch_d.csrc = ptr_next[0];
                ch_d.cdst = ptr_next[1];
                ch_d.ccnt = ch_q.ccnt - CW'(1);
                if (ch_q.ccnt == CW'(1)) begin
                    if (ch_q.rpt) begin
                        ch_d.csrc = ch_q.bsrc;
                        ch_d.cdst = ch_q.bdst;
                        ch_d.ccnt = ch_q.bcnt;
                    end else begin
                        ch_d.en   = 1'b0;
                        ch_d.done = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q <= '0;
        end else begin
            ch_q <= ch_d;
        end
    end

    always_comb begin
        case (cfg_addr)
            REG_CTRL: cfg_rdata = RW'({ch_q.rpt, ch_q.inc, ch_q.word, ch_q.en});
            REG_SRC:  cfg_rdata = RW'(ch_q.csrc);
            REG_DST:  cfg_rdata = RW'(ch_q.cdst);
            default:  cfg_rdata = RW'(ch_q.ccnt);
        endcase
    end

    assign mem_rd    = (ch_q.st == ST_READ);
    assign mem_wr    = (ch_q.st == ST_WRITE);
    assign mem_word  = ch_q.word;
    assign mem_addr  = (ch_q.st == ST_READ) ? ch_q.csrc : ch_q.cdst;
    assign mem_wdata = ch_q.word ? mem_rdata : DW'(mem_rdata[7:0]);
    assign busy      = (ch_q.st != ST_IDLE);
    assign done      = ch_q.done;

    // R11
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R11
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(mem_rd));

    // R8
    done_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ch_q.en && !busy);

    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_q.st == ST_UPDATE && !cfg_we) |=>
            ((ch_q.ccnt == $past(ch_q.ccnt) - CW'(1)) || (ch_q.ccnt == ch_q.bcnt)));

    // R9
    rpt_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_q.st == ST_UPDATE && ch_q.rpt && !cfg_we) |=> !done);

endmodule

// File: tb/sim_dma_repeat_chan.sv
`timescale 1ns/1ps
module sim_dma_repeat_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic [15:0] cfg_rdata;
    logic        hw_req = 1'b0;
    logic        mem_rd, mem_wr, mem_word;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = 16'd0;
    logic        busy, done;

    logic [7:0]  mem [0:255];
    int tests = 0, fails = 0;
    int done_cnt = 0, rd_cnt = 0, wr_cnt = 0, bad_seq = 0;
    logic rd_prev = 1'b0;
    bit finished = 0;

    always #10 clk = ~clk;

    dma_repeat_chan u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .hw_req(hw_req),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_word(mem_word),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done)
    );

    // byte-addressed memory, one cycle read latency
    always @(posedge clk) begin
        if (mem_rd)
            mem_rdata <= mem_word ? {mem[mem_addr[7:0] + 8'd1], mem[mem_addr[7:0]]}
                                  : {8'h00, mem[mem_addr[7:0]]};
        if (mem_wr) begin
            mem[mem_addr[7:0]] <= mem_wdata[7:0];
            if (mem_word) mem[mem_addr[7:0] + 8'd1] <= mem_wdata[15:8];
        end
    end

    // bus monitor
    always @(posedge clk) begin
        if (done) done_cnt++;
        if (mem_rd) rd_cnt++;
        if (mem_wr) wr_cnt++;
        if ((mem_wr && !rd_prev) || (mem_rd && mem_wr)) bad_seq++;
        rd_prev <= mem_rd;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        mem[a] <= v;
    endtask

    task automatic wreg(input logic [1:0] a, input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rreg(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        cfg_addr = a;
        #1 v = cfg_rdata;
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    task automatic setup(input logic [15:0] s, input logic [15:0] d,
                         input logic [15:0] n, input logic [15:0] ctl);
        wreg(2'd1, s); wreg(2'd2, d); wreg(2'd3, n); wreg(2'd0, ctl);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 rd/wr", {mem_rd, mem_wr}, 0);
        rreg(2'd0, v); chk("R1 ctrl", v, 0);
        rreg(2'd3, v); chk("R1 count", v, 0);
    endtask

    task automatic t_word_single();
        logic [15:0] v;
        int d0;
        poke(8'h10, 8'h11); poke(8'h11, 8'h22); poke(8'h12, 8'h33);
        poke(8'h13, 8'h44); poke(8'h14, 8'h55); poke(8'h15, 8'h66);
        setup(16'h10, 16'h40, 16'd3, 16'h0007);
        d0 = done_cnt;
        wreg(2'd0, 16'h0027); settle();
        chk("R2 word lo", mem[8'h40], 8'h11);
        chk("R2 word hi", mem[8'h41], 8'h22);
        rreg(2'd3, v); chk("R7 count after 1", v, 2);
        rreg(2'd1, v); chk("R4 src +2", v, 16'h12);
        rreg(2'd2, v); chk("R4 dst fixed", v, 16'h40);
        wreg(2'd0, 16'h0027); settle();
        chk("R2 second word", {mem[8'h41], mem[8'h40]}, 16'h4433);
        chk("R8 no done yet", done_cnt - d0, 0);
        wreg(2'd0, 16'h0027); settle();
        chk("R2 third word", {mem[8'h41], mem[8'h40]}, 16'h6655);
        chk("R8 one done cycle", done_cnt - d0, 1);
        rreg(2'd0, v); chk("R8 enable cleared", v[0], 0);
        rreg(2'd3, v); chk("R7 count zero", v, 0);
        poke(8'h40, 8'h00);
        wreg(2'd0, 16'h0026); settle();
        chk("R8 stopped no move", mem[8'h40], 8'h00);
    endtask

    task automatic t_byte_dst();
        logic [15:0] v;
        poke(8'h20, 8'hA5); poke(8'h21, 8'h5A);
        poke(8'h60, 8'h00); poke(8'h61, 8'h77);
        setup(16'h20, 16'h60, 16'd2, 16'h0009);
        wreg(2'd0, 16'h0029); settle();
        chk("R3 byte moved", mem[8'h60], 8'hA5);
        chk("R3 neighbour kept", mem[8'h61], 8'h77);
        rreg(2'd2, v); chk("R4 dst +1", v, 16'h61);
        rreg(2'd1, v); chk("R4 src fixed", v, 16'h20);
        wreg(2'd0, 16'h0029); settle();
        chk("R4 dst stepped write", mem[8'h61], 8'hA5);
    endtask

    task automatic t_no_inc();
        logic [15:0] v;
        poke(8'h24, 8'h3C); poke(8'h68, 8'h00);
        setup(16'h24, 16'h68, 16'd3, 16'h0001);
        wreg(2'd0, 16'h0021); settle();
        wreg(2'd0, 16'h0021); settle();
        chk("R4 none data", mem[8'h68], 8'h3C);
        rreg(2'd1, v); chk("R4 none src", v, 16'h24);
        rreg(2'd2, v); chk("R4 none dst", v, 16'h68);
        rreg(2'd3, v); chk("R7 count 1", v, 1);
    endtask

    task automatic t_hw();
        logic [15:0] v;
        setup(16'h24, 16'h6A, 16'd4, 16'h0001);
        @(negedge clk) hw_req = 1'b1;
        repeat (20) @(negedge clk);
        rreg(2'd3, v); chk("R5 level one transfer", v, 3);
        @(negedge clk) hw_req = 1'b0;
        @(negedge clk) hw_req = 1'b1;
        @(negedge clk) hw_req = 1'b0;
        settle();
        rreg(2'd3, v); chk("R5 second edge", v, 2);
        chk("R5 data", mem[8'h6A], 8'h3C);
    endtask

    task automatic t_merge();
        logic [15:0] v;
        setup(16'h24, 16'h6C, 16'd5, 16'h0001);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 16'h0021;
        repeat (3) @(negedge clk);
        cfg_we = 1'b0;
        repeat (14) @(negedge clk);
        rreg(2'd3, v); chk("R6 two transfers", v, 3);
    endtask

    task automatic t_repeat();
        logic [15:0] v;
        int d0;
        poke(8'h30, 8'hC1); poke(8'h31, 8'hD2);
        setup(16'h30, 16'h80, 16'd2, 16'h001B);
        d0 = done_cnt;
        wreg(2'd0, 16'h003B); settle();
        wreg(2'd0, 16'h003B); settle();
        chk("R9 first slot", {mem[8'h81], mem[8'h80]}, 16'hD2C1);
        chk("R9 second slot", {mem[8'h83], mem[8'h82]}, 16'hD2C1);
        rreg(2'd3, v); chk("R9 count reloaded", v, 2);
        rreg(2'd2, v); chk("R9 dst reloaded", v, 16'h80);
        rreg(2'd0, v); chk("R9 still enabled", v[0], 1);
        chk("R9 no done", done_cnt - d0, 0);
        poke(8'h30, 8'hE7);
        wreg(2'd0, 16'h003B); settle();
        chk("R9 wraps to start", mem[8'h80], 8'hE7);
    endtask

    task automatic t_disabled();
        logic [15:0] v;
        poke(8'h90, 8'h00);
        setup(16'h24, 16'h90, 16'd2, 16'h0000);
        wreg(2'd0, 16'h0020); settle();
        @(negedge clk) hw_req = 1'b1;
        @(negedge clk) hw_req = 1'b0;
        settle();
        chk("R10 no data", mem[8'h90], 8'h00);
        rreg(2'd3, v); chk("R10 count kept", v, 2);
        chk("R10 idle", busy, 0);
    endtask

    task automatic t_bus();
        chk("R11 rd equals wr", rd_cnt, wr_cnt);
        chk("R11 order", bad_seq, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word_single();
        t_byte_dst();
        t_no_inc();
        t_hw();
        t_merge();
        t_repeat();
        t_disabled();
        t_bus();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end
endmodule